// File: doc/BRIEF.md
# Display RAM Write Address Pointer Generator

This block produces the write address for a display RAM of 102 columns by 68 rows, where the rows are grouped into 8-row banks. It keeps a column pointer and a bank pointer. A command decoder upstream loads either pointer directly and supplies a mode word. Each data byte is presented with a write strobe. The block then issues one registered RAM write cycle, using the address the pointers held before they advanced, and afterwards steps the pointers in the order the mode selects.

The bank range has gaps. Banks 0 through 8 are the normal picture area, and bank 8 carries only three rows. There is no bank 9. Bank 10 is a single row set aside for icon data. Automatic stepping never reaches bank 10; only an explicit bank load selects it. Once selected, it stays selected while the column pointer wraps. Column and bank mirroring are applied to the emitted address only. The pointers themselves always count in logical order.

Top module: `dram_addr_gen`

## Requirements
- R1: After a synchronous reset, both pointers are 0, the mode is horizontal with no mirroring, `ram_wr_en` and `cmd_err` are 0, and the first write goes to column 0, bank 0.
- R2: A write strobe accepted at a clock edge produces `ram_wr_en`=1 for exactly the following cycle, with `ram_data` equal to the strobed byte and the address taken from the pointers before they advance.
- R3: In horizontal mode (`cfg_vert`=0) with bank 0..8, each write increments the column. A write at column 101 sets the column to 0 and steps the bank by one.
- R4: In vertical mode (`cfg_vert`=1) with bank 0..8, each write increments the bank. A write at bank 8 sets the bank to 0 and steps the column by one.
- R5: In either mode, a write at column 101, bank 8 returns both pointers to column 0, bank 0.
- R6: Bank 10 is entered only through a bank load of value 10. While the bank is 10, every write increments the column regardless of `cfg_vert`, column 101 wraps to 0, and the bank stays 10.
- R7: A column load above 101, or a bank load of 9 or of 11..15, leaves that pointer unchanged and raises `cmd_err` for one cycle after the load edge. A valid load does not raise `cmd_err`.
- R8: With `cfg_mx`=1, the emitted column is 101 minus the column pointer.
- R9: With `cfg_my`=1, the emitted bank is 8 minus the bank pointer for banks 0..8, and bank 10 is emitted as 10.
- R10: When a column or bank load coincides with a write strobe, the load takes effect, the strobe is discarded, no RAM write is issued, and the pointers do not advance.
- R11: Mode bits are taken from `cfg_vert`, `cfg_mx` and `cfg_my` on a clock edge where `cfg_ld`=1, and they keep their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ld | input | 1 | Load mode bits this cycle |
| cfg_vert | input | 1 | 1 = vertical stepping, 0 = horizontal |
| cfg_mx | input | 1 | Column mirror enable |
| cfg_my | input | 1 | Bank mirror enable |
| setx_en | input | 1 | Column pointer load strobe |
| setx_val | input | 7 | Column load value |
| sety_en | input | 1 | Bank pointer load strobe |
| sety_val | input | 4 | Bank load value |
| wr_stb | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte |
| ram_wr_en | output | 1 | Registered RAM write enable |
| ram_col | output | 7 | Registered physical column |
| ram_bank | output | 4 | Registered physical bank |
| ram_data | output | 8 | Registered write data |
| cmd_err | output | 1 | One-cycle pulse on a rejected load |

## Verification
The bench targets the wrap corners. At column 101 in horizontal mode, a design that wraps the column without stepping the bank would write a row twice. At the joint corner (101, 8), a design that is wrong there would step into the missing bank 9, or into bank 10, instead of returning to the origin. Writes in the icon bank are run in vertical mode to catch a design that lets the mode bit move the bank. They are also run across the column wrap to catch one that leaves bank 10. Rejected loads of 9 and 11 to the bank, and of 102 to the column, are each followed by a write to show the pointer kept its old value. A load given together with a write must yield no RAM cycle, and a design that lets the write through would emit a stray write.

// File: rtl/dram_addr_pkg.sv
package dram_addr_pkg;
  localparam int unsigned XW = 7;
  localparam int unsigned YW = 4;
  localparam int unsigned DW = 8;

  typedef struct packed {
    logic vert;
    logic mx;
    logic my;
  } mode_t;
endpackage

// File: rtl/dram_cmd_check.sv
module dram_cmd_check #(
  parameter int unsigned XW     = 7,
  parameter int unsigned YW     = 4,
  parameter int unsigned X_LAST = 101,
  parameter int unsigned Y_LAST = 8,
  parameter int unsigned Y_ICON = 10
) (
  input  logic [XW-1:0] setx_val,
  input  logic [YW-1:0] sety_val,
  output logic          x_ok,
  output logic          y_ok
);
  always_comb begin
    x_ok = (32'(setx_val) <= X_LAST);
    y_ok = (32'(sety_val) <= Y_LAST) || (32'(sety_val) == Y_ICON);
  end
endmodule

// File: rtl/dram_ptr_step.sv
module dram_ptr_step #(
  parameter int unsigned XW     = 7,
  parameter int unsigned YW     = 4,
  parameter int unsigned X_LAST = 101,
  parameter int unsigned Y_LAST = 8,
  parameter int unsigned Y_ICON = 10
) (
  input  logic [XW-1:0] x_cur,
  input  logic [YW-1:0] y_cur,
  input  logic          vert,
  output logic [XW-1:0] x_nxt,
  output logic [YW-1:0] y_nxt
);
  localparam logic [XW-1:0] XL = XW'(X_LAST);
  localparam logic [YW-1:0] YL = YW'(Y_LAST);
  localparam logic [YW-1:0] YI = YW'(Y_ICON);

  logic x_end, y_end, icon;

  always_comb begin
    x_end = (x_cur == XL);
    y_end = (y_cur == YL);
    icon  = (y_cur == YI);
    x_nxt = x_cur;
    y_nxt = y_cur;
    if (icon || !vert) begin
      x_nxt = x_end ? '0 : x_cur + 1'b1;
      if (!icon && x_end)
        y_nxt = y_end ? '0 : y_cur + 1'b1;
    end else begin
      y_nxt = y_end ? '0 : y_cur + 1'b1;
      if (y_end)
        x_nxt = x_end ? '0 : x_cur + 1'b1;
    end
  end
endmodule

// File: rtl/dram_addr_mirror.sv
module dram_addr_mirror #(
  parameter int unsigned XW     = 7,
  parameter int unsigned YW     = 4,
  parameter int unsigned X_LAST = 101,
  parameter int unsigned Y_LAST = 8,
  parameter int unsigned Y_ICON = 10
) (
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  input  logic          mx,
  input  logic          my,
  output logic [XW-1:0] col_out,
  output logic [YW-1:0] bank_out
);
  localparam logic [XW-1:0] XL = XW'(X_LAST);
  localparam logic [YW-1:0] YL = YW'(Y_LAST);
  localparam logic [YW-1:0] YI = YW'(Y_ICON);

  always_comb begin
    col_out  = mx ? (XL - x_in) : x_in;
    bank_out = (my && (y_in != YI)) ? (YL - y_in) : y_in;
  end
endmodule

// File: rtl/dram_addr_gen.sv
module dram_addr_gen #(
  parameter int unsigned COLS   = 102,
  parameter int unsigned BANKS  = 9,
  parameter int unsigned Y_ICON = 10,
  parameter int unsigned XW     = dram_addr_pkg::XW,
  parameter int unsigned YW     = dram_addr_pkg::YW,
  parameter int unsigned DW     = dram_addr_pkg::DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_ld,
  input  logic          cfg_vert,
  input  logic          cfg_mx,
  input  logic          cfg_my,
  input  logic          setx_en,
  input  logic [XW-1:0] setx_val,
  input  logic          sety_en,
  input  logic [YW-1:0] sety_val,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          ram_wr_en,
  output logic [XW-1:0] ram_col,
  output logic [YW-1:0] ram_bank,
  output logic [DW-1:0] ram_data,
  output logic          cmd_err
);
  import dram_addr_pkg::*;

  localparam int unsigned X_LAST = COLS - 1;
  localparam int unsigned Y_LAST = BANKS - 1;

  logic [XW-1:0] x_q, x_nxt, col_m;
  logic [YW-1:0] y_q, y_nxt, bank_m;
  mode_t         mode_q;
  logic          x_ok, y_ok, any_set;

  dram_cmd_check #(.XW(XW), .YW(YW), .X_LAST(X_LAST), .Y_LAST(Y_LAST), .Y_ICON(Y_ICON))
    u_chk (.setx_val(setx_val), .sety_val(sety_val), .x_ok(x_ok), .y_ok(y_ok));

  dram_ptr_step #(.XW(XW), .YW(YW), .X_LAST(X_LAST), .Y_LAST(Y_LAST), .Y_ICON(Y_ICON))
    u_step (.x_cur(x_q), .y_cur(y_q), .vert(mode_q.vert), .x_nxt(x_nxt), .y_nxt(y_nxt));

  dram_addr_mirror #(.XW(XW), .YW(YW), .X_LAST(X_LAST), .Y_LAST(Y_LAST), .Y_ICON(Y_ICON))
    u_mir (.x_in(x_q), .y_in(y_q), .mx(mode_q.mx), .my(mode_q.my),
           .col_out(col_m), .bank_out(bank_m));

  assign any_set = setx_en | sety_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q       <= '0;
      y_q       <= '0;
      mode_q    <= '0;
      ram_wr_en <= 1'b0;
      ram_col   <= '0;
      ram_bank  <= '0;
      ram_data  <= '0;
      cmd_err   <= 1'b0;
    end else begin
      ram_wr_en <= 1'b0;
      cmd_err   <= (setx_en && !x_ok) || (sety_en && !y_ok);
      if (cfg_ld)
        mode_q <= '{vert: cfg_vert, mx: cfg_mx, my: cfg_my};
      if (setx_en && x_ok)
        x_q <= setx_val;
      if (sety_en && y_ok)
        y_q <= sety_val;
      if (!any_set && wr_stb) begin
        ram_wr_en <= 1'b1;
        ram_col   <= col_m;
        ram_bank  <= bank_m;
        ram_data  <= wr_data;
        x_q       <= x_nxt;
        y_q       <= y_nxt;
      end
    end
  end
endmodule

// File: rtl/dram_addr_gen_chk.sv
module dram_addr_gen_chk #(
  parameter int unsigned XW     = 7,
  parameter int unsigned YW     = 4,
  parameter int unsigned X_LAST = 101,
  parameter int unsigned Y_LAST = 8,
  parameter int unsigned Y_ICON = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          setx_en,
  input logic [XW-1:0] setx_val,
  input logic          sety_en,
  input logic          wr_stb,
  input logic          ram_wr_en,
  input logic [XW-1:0] ram_col,
  input logic [YW-1:0] ram_bank,
  input logic          cmd_err,
  input logic [XW-1:0] x_q,
  input logic [YW-1:0] y_q
);
  a_r2_write_follows: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !setx_en && !sety_en) |=> ram_wr_en);

  a_r10_load_blocks_write: assert property (@(posedge clk) disable iff (rst)
    (setx_en || sety_en) |=> !ram_wr_en);

  a_r7_err_needs_load: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(setx_en || sety_en));

  a_r7_bad_x_kept: assert property (@(posedge clk) disable iff (rst)
    (setx_en && (32'(setx_val) > X_LAST)) |=> $stable(x_q));

  a_r8_col_in_range: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> (32'(ram_col) <= X_LAST));

  a_r9_bank_legal: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> ((32'(ram_bank) <= Y_LAST) || (32'(ram_bank) == Y_ICON)));

  a_r6_icon_sticky: assert property (@(posedge clk) disable iff (rst)
    ((32'(y_q) == Y_ICON) && !sety_en) |=> (32'(y_q) == Y_ICON));
endmodule

bind dram_addr_gen dram_addr_gen_chk #(
  .XW(XW), .YW(YW), .X_LAST(X_LAST), .Y_LAST(Y_LAST), .Y_ICON(Y_ICON)
) u_chk_bind (
  .clk(clk), .rst(rst), .setx_en(setx_en), .setx_val(setx_val), .sety_en(sety_en),
  .wr_stb(wr_stb), .ram_wr_en(ram_wr_en), .ram_col(ram_col), .ram_bank(ram_bank),
  .cmd_err(cmd_err), .x_q(x_q), .y_q(y_q)
);

// File: tb/dram_addr_gen_tb.sv
module dram_addr_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_ld = 0, cfg_vert = 0, cfg_mx = 0, cfg_my = 0;
  logic       setx_en = 0, sety_en = 0, wr_stb = 0;
  logic [6:0] setx_val = '0;
  logic [3:0] sety_val = '0;
  logic [7:0] wr_data = '0;
  logic       ram_wr_en, cmd_err;
  logic [6:0] ram_col;
  logic [3:0] ram_bank;
  logic [7:0] ram_data;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dram_addr_gen u_dut (
    .clk(clk), .rst(rst), .cfg_ld(cfg_ld), .cfg_vert(cfg_vert), .cfg_mx(cfg_mx),
    .cfg_my(cfg_my), .setx_en(setx_en), .setx_val(setx_val), .sety_en(sety_en),
    .sety_val(sety_val), .wr_stb(wr_stb), .wr_data(wr_data), .ram_wr_en(ram_wr_en),
    .ram_col(ram_col), .ram_bank(ram_bank), .ram_data(ram_data), .cmd_err(cmd_err)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] val;
    logic [6:0] col;
    logic [3:0] bank;
    logic       err;
  } vec_t;

  localparam logic [1:0] OP_W = 2'd0, OP_X = 2'd1, OP_Y = 2'd2, OP_M = 2'd3;
  localparam int NV = 42;
  localparam vec_t VEC [NV] = '{
    '{OP_W, 8'h11, 7'd0,   4'd0,  1'b0},
    '{OP_W, 8'h12, 7'd1,   4'd0,  1'b0},
    '{OP_X, 8'd101, 7'd0,  4'd0,  1'b0},
    '{OP_W, 8'h13, 7'd101, 4'd0,  1'b0},
    '{OP_W, 8'h14, 7'd0,   4'd1,  1'b0},
    '{OP_Y, 8'd9,  7'd0,   4'd0,  1'b1},
    '{OP_W, 8'h15, 7'd1,   4'd1,  1'b0},
    '{OP_X, 8'd102, 7'd0,  4'd0,  1'b1},
    '{OP_W, 8'h16, 7'd2,   4'd1,  1'b0},
    '{OP_Y, 8'd8,  7'd0,   4'd0,  1'b0},
    '{OP_X, 8'd101, 7'd0,  4'd0,  1'b0},
    '{OP_W, 8'h17, 7'd101, 4'd8,  1'b0},
    '{OP_W, 8'h18, 7'd0,   4'd0,  1'b0},
    '{OP_M, 8'd1,  7'd0,   4'd0,  1'b0},
    '{OP_X, 8'd5,  7'd0,   4'd0,  1'b0},
    '{OP_Y, 8'd7,  7'd0,   4'd0,  1'b0},
    '{OP_W, 8'h21, 7'd5,   4'd7,  1'b0},
    '{OP_W, 8'h22, 7'd5,   4'd8,  1'b0},
    '{OP_W, 8'h23, 7'd6,   4'd0,  1'b0},
    '{OP_X, 8'd101, 7'd0,  4'd0,  1'b0},
    '{OP_Y, 8'd8,  7'd0,   4'd0,  1'b0},
    '{OP_W, 8'h24, 7'd101, 4'd8,  1'b0},
    '{OP_W, 8'h25, 7'd0,   4'd0,  1'b0},
    '{OP_Y, 8'd10, 7'd0,   4'd0,  1'b0},
    '{OP_X, 8'd100, 7'd0,  4'd0,  1'b0},
    '{OP_W, 8'h31, 7'd100, 4'd10, 1'b0},
    '{OP_W, 8'h32, 7'd101, 4'd10, 1'b0},
    '{OP_W, 8'h33, 7'd0,   4'd10, 1'b0},
    '{OP_W, 8'h34, 7'd1,   4'd10, 1'b0},
    '{OP_Y, 8'd11, 7'd0,   4'd0,  1'b1},
    '{OP_W, 8'h35, 7'd2,   4'd10, 1'b0},
    '{OP_M, 8'd6,  7'd0,   4'd0,  1'b0},
    '{OP_X, 8'd0,  7'd0,   4'd0,  1'b0},
    '{OP_W, 8'h41, 7'd101, 4'd10, 1'b0},
    '{OP_Y, 8'd0,  7'd0,   4'd0,  1'b0},
    '{OP_X, 8'd0,  7'd0,   4'd0,  1'b0},
    '{OP_W, 8'h42, 7'd101, 4'd8,  1'b0},
    '{OP_W, 8'h43, 7'd100, 4'd8,  1'b0},
    '{OP_Y, 8'd2,  7'd0,   4'd0,  1'b0},
    '{OP_W, 8'h44, 7'd99,  4'd6,  1'b0},
    '{OP_Y, 8'd15, 7'd0,   4'd0,  1'b1},
    '{OP_W, 8'h45, 7'd98,  4'd6,  1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_mode(input logic v, input logic mx, input logic my);
    @(negedge clk);
    cfg_ld = 1; cfg_vert = v; cfg_mx = mx; cfg_my = my;
    @(negedge clk);
    cfg_ld = 0;
  endtask

  task automatic do_setx(input logic [6:0] v, input bit exp_err, input string tag);
    @(negedge clk);
    setx_en = 1; setx_val = v;
    @(negedge clk);
    setx_en = 0;
    chk(cmd_err == exp_err, tag, int'(cmd_err), int'(exp_err));
  endtask

  task automatic do_sety(input logic [3:0] v, input bit exp_err, input string tag);
    @(negedge clk);
    sety_en = 1; sety_val = v;
    @(negedge clk);
    sety_en = 0;
    chk(cmd_err == exp_err, tag, int'(cmd_err), int'(exp_err));
  endtask

  task automatic do_write(input logic [7:0] d, input int ecol, input int ebank, input string tag);
    @(negedge clk);
    wr_stb = 1; wr_data = d;
    @(negedge clk);
    wr_stb = 0;
    chk(ram_wr_en && int'(ram_col) == ecol && int'(ram_bank) == ebank, tag,
        int'(ram_col) * 100 + int'(ram_bank), ecol * 100 + ebank);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: idle outputs after reset
    chk(!ram_wr_en && !cmd_err, "R1 idle after reset", int'(ram_wr_en) + int'(cmd_err), 0);

    // Vector table: R2 R3 R5 R4 R6 R7 R8 R9; mode val bit0 vert, bit1 mx, bit2 my
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_W: do_write(VEC[i].val, int'(VEC[i].col), int'(VEC[i].bank), $sformatf("R3/R4/R5/R6/R8/R9 vec %0d", i));
        OP_X: do_setx(VEC[i].val[6:0], VEC[i].err, $sformatf("R7 setx vec %0d", i));
        OP_Y: do_sety(VEC[i].val[3:0], VEC[i].err, $sformatf("R7 sety vec %0d", i));
        default: do_mode(VEC[i].val[0], VEC[i].val[1], VEC[i].val[2]);
      endcase
    end

    // R2: data and one-cycle enable
    do_write(8'hA5, 97, 6, "R2 addr");
    chk(ram_data == 8'hA5, "R2 data", int'(ram_data), 8'hA5);
    @(negedge clk);
    chk(!ram_wr_en, "R2 single cycle", int'(ram_wr_en), 0);

    // R7: error pulse lasts one cycle
    do_setx(7'd120, 1'b1, "R7 bad x err");
    @(negedge clk);
    chk(!cmd_err, "R7 err one cycle", int'(cmd_err), 0);

    // R1: reset restores defaults mid-run
    do_reset();
    do_write(8'h01, 0, 0, "R1 first write origin");
    do_write(8'h02, 1, 0, "R1 horizontal default");

    // R10: load together with write
    @(negedge clk);
    setx_en = 1; setx_val = 7'd50; wr_stb = 1;
    @(negedge clk);
    setx_en = 0; wr_stb = 0;
    chk(!ram_wr_en, "R10 no write on collision", int'(ram_wr_en), 0);
    do_write(8'h03, 50, 0, "R10 load applied, no advance");

    // R11: mode held without cfg_ld
    @(negedge clk);
    cfg_vert = 1; cfg_mx = 1; cfg_my = 1;
    do_write(8'h04, 51, 0, "R11 mode held without load");
    cfg_vert = 0; cfg_mx = 0; cfg_my = 0;

    // R3 R5: full horizontal sweep
    do_setx(7'd0, 1'b0, "R7 valid x");
    do_sety(4'd0, 1'b0, "R7 valid y");
    begin
      int ex = 0, ey = 0;
      for (int n = 0; n < 102 * 9 + 1; n++) begin
        do_write(8'(n), ex, ey, "R3 horizontal sweep");
        if (ex == 101) begin ex = 0; ey = (ey == 8) ? 0 : ey + 1; end
        else ex++;
      end
    end

    // R4 R5: full vertical sweep
    do_mode(1'b1, 1'b0, 1'b0);
    do_setx(7'd0, 1'b0, "R7 valid x");
    do_sety(4'd0, 1'b0, "R7 valid y");
    begin
      int ex = 0, ey = 0;
      for (int n = 0; n < 102 * 9 + 1; n++) begin
        do_write(8'(n), ex, ey, "R4 vertical sweep");
        if (ey == 8) begin ey = 0; ex = (ex == 101) ? 0 : ex + 1; end
        else ey++;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule